// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block sits between a register bus and a one-time-programmable fuse array and reads the array on behalf of software. Software first writes a timing register. That register holds a setup count and a strobe count, both in bus-clock cycles. Software then writes a command register with a byte start address, a length-minus-one in bytes and a read request bit. The block steps through the requested fuse words one at a time. For each word it holds the address, pulses the read strobe and captures the returned word.

Captured words land in a bank of eight 32-bit result registers, lowest address first. When the last requested word has been stored, the block raises a done flag and clears the request bit. Software polls the done flag and then reads the results. A normal command asks for 32 bytes at a 32-byte boundary, which fills the whole bank. A shorter length fills only the first few result registers and leaves the others as they were.

The block also holds fields for fuse programming: a program enable, a write enable and the write timing counts. It stores them and reads them back, but they never cause any activity on the fuse array.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset every register reads 0, and `fuse_en` and `fuse_strobe` are low.
- R2: A write to word 0 (command) with bit 0 = 1 while no read runs starts a read. Status bit 0 (done) reads 0 from the next cycle on. The command register reads back the start byte address in bits [30:21], the length-minus-one in [20:16], program enable in bit 15, write enable in bit 1 and read request in bit 0.
- R3: Word k of a read (k counted from 0) addresses fuse word ((start >> 2) + k) mod 256. Its setup phase keeps `fuse_en` high and `fuse_strobe` low for (adjust + 1) cycles. Adjust is the 4-bit field in timing bits [23:20].
- R4: After the setup phase, `fuse_strobe` stays high for (strobe + 4) cycles. Strobe is the 4-bit field in timing bits [19:16]. The whole access therefore lasts (adjust + 5 + strobe) cycles, and the address is stable throughout.
- R5: A read covers ((length-minus-one >> 2) + 1) words. Result register n, at word index 3 + n, receives fuse word (start >> 2) + n. Result registers beyond the count keep their earlier values.
- R6: When the last word is stored, status bit 0 becomes 1 and command bit 0 becomes 0. Done stays 1 until the next read request.
- R7: A command write while a read runs is ignored. The command fields stay unchanged and the running read continues with its original address.
- R8: A command write with bit 0 = 0 only stores the fields: no fuse access happens and done is unchanged. Status bit 1 (write done) always reads 0.
- R9: The timing register (word 1) reads back interrupt enable in bit 31, read adjust in [23:20], read strobe in [19:16], write adjust in [15:12] and write strobe in [11:0]. Bits [30:24] read 0.
- R10: Writes to status (word 2) and to the result registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_idx | input | 4 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_idx (combinational) |
| fuse_addr | output | 9 | Fuse word address |
| fuse_en | output | 1 | Access active (setup and strobe phases) |
| fuse_strobe | output | 1 | Read strobe to the fuse array |
| fuse_rdata | input | 32 | Word returned by the fuse array |

## Verification
The bench uses the default parameters: eight result registers, a 9-bit fuse address and a 10-bit byte address, so the fuse space is 256 words. With those values every one of the 256 adjust/strobe pairs can be swept, and the setup and strobe widths are measured for each access. The sweep also moves the start across all 32 chunk boundaries and all eight lengths. Further cases cover an unaligned start, a partial read over an earlier full read, a command during a slow read, a store-only command, and writes to the read-only words.

// File: rtl/fuse_rd_ctrl.sv
`timescale 1ns/1ps
module fuse_rd_ctrl #(
  parameter int NDATA   = 8,
  parameter int FUSE_AW = 9,
  parameter int BYTE_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_idx,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [FUSE_AW-1:0] fuse_addr,
  output logic        fuse_en,
  output logic        fuse_strobe,
  input  logic [31:0] fuse_rdata
);
  localparam int IDX_W   = $clog2(NDATA);
  localparam int WORD_AW = BYTE_AW - 2;
  localparam int CNT_W   = 6;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_CAPTURE, S_DONE} st_t;
  st_t st;

  logic [BYTE_AW-1:0] c_addr;
  logic [4:0]         c_len;
  logic               c_pg, c_wr, c_rd;
  logic               t_int;
  logic [3:0]         rd_adj, rd_str, wr_adj;
  logic [11:0]        wr_str;
  logic               rd_done;
  logic [31:0]        dreg [NDATA];
  logic [IDX_W-1:0]   idx;
  logic [CNT_W-1:0]   cnt;

  wire busy   = (st != S_IDLE);
  wire wr_ctl = bus_sel && bus_we && (bus_idx == 4'd0);
  wire wr_cfg = bus_sel && bus_we && (bus_idx == 4'd1);
  wire start  = wr_ctl && !busy && bus_wdata[0];
  wire [IDX_W-1:0]   last  = IDX_W'(c_len[4:2]);
  wire [WORD_AW-1:0] wbase = c_addr[BYTE_AW-1:2];

  assign fuse_addr   = FUSE_AW'(wbase + WORD_AW'(idx));
  assign fuse_en     = (st == S_SETUP) || (st == S_STROBE);
  assign fuse_strobe = (st == S_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_addr <= '0; c_len <= '0; c_pg <= 1'b0; c_wr <= 1'b0; c_rd <= 1'b0;
    end else if (wr_ctl && !busy) begin
      c_addr <= bus_wdata[21 +: BYTE_AW];
      c_len  <= bus_wdata[20:16];
      c_pg   <= bus_wdata[15];
      c_wr   <= bus_wdata[1];
      c_rd   <= bus_wdata[0];
    end else if (st == S_DONE) begin
      c_rd <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_int <= 1'b0; rd_adj <= '0; rd_str <= '0; wr_adj <= '0; wr_str <= '0;
    end else if (wr_cfg) begin
      t_int  <= bus_wdata[31];
      rd_adj <= bus_wdata[23:20];
      rd_str <= bus_wdata[19:16];
      wr_adj <= bus_wdata[15:12];
      wr_str <= bus_wdata[11:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0; rd_done <= 1'b0;
      for (int i = 0; i < NDATA; i++) dreg[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_SETUP; idx <= '0; cnt <= '0; rd_done <= 1'b0;
        end
        S_SETUP: if (cnt == CNT_W'(rd_adj)) begin
          st <= S_STROBE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_STROBE: if (cnt == CNT_W'(rd_str) + CNT_W'(3)) begin
          st <= S_CAPTURE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_CAPTURE: begin
          dreg[idx] <= fuse_rdata;
          if (idx == last) st <= S_DONE;
          else begin
            idx <= idx + 1'b1; st <= S_SETUP;
          end
        end
        S_DONE: begin
          rd_done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_idx)
      4'd0: begin
        bus_rdata[21 +: BYTE_AW] = c_addr;
        bus_rdata[20:16] = c_len;
        bus_rdata[15]    = c_pg;
        bus_rdata[1]     = c_wr;
        bus_rdata[0]     = c_rd;
      end
      4'd1: bus_rdata = {t_int, 7'd0, rd_adj, rd_str, wr_adj, wr_str};
      4'd2: bus_rdata = {31'd0, rd_done};
      default:
        for (int i = 0; i < NDATA; i++)
          if (bus_idx == 4'(i + 3)) bus_rdata = dreg[i];
    endcase
  end

  logic [CNT_W-1:0] su_run, sr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su_run <= '0; sr_run <= '0;
    end else begin
      su_run <= (fuse_en && !fuse_strobe) ? su_run + 1'b1 : '0;
      sr_run <= fuse_strobe ? sr_run + 1'b1 : '0;
    end
  end

  p_setup_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_strobe) |-> su_run == CNT_W'(rd_adj) + CNT_W'(1));
  p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_strobe) |-> sr_run == CNT_W'(rd_str) + CNT_W'(4));
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |=> (!fuse_strobe || $stable(fuse_addr)));
  p_strobe_in_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_strobe |-> fuse_en);
  p_capture_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAPTURE) |-> $past(fuse_strobe));
  p_done_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_done) |-> !c_rd);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctl) |=> ($stable(c_addr) && $stable(c_len)));
endmodule

// File: tb/sim_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module sim_fuse_rd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_idx = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [8:0] fuse_addr;
  logic fuse_en, fuse_strobe;
  logic [31:0] fuse_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int exp_adj = 0, exp_str = 0, exp_base = 0, acc_idx = 0;
  int su = 0, sr = 0;
  logic prev_sr = 1'b0;
  logic [8:0] seen_addr = '0;
  logic [31:0] exp_data [8];

  always #4 clk = ~clk;

  fuse_rd_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_addr(fuse_addr), .fuse_en(fuse_en), .fuse_strobe(fuse_strobe),
    .fuse_rdata(fuse_rdata));

  function automatic logic [31:0] fval(input logic [7:0] w);
    return {w, ~w, w ^ 8'hA5, w + 8'h3C};
  endfunction

  always @(posedge clk) if (fuse_strobe) fuse_rdata <= fval(fuse_addr[7:0]);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (fuse_en && !fuse_strobe) su++;
    if (fuse_strobe) begin sr++; seen_addr = fuse_addr; end
    if (prev_sr && !fuse_strobe) begin
      check("R3 setup cycles", su, exp_adj + 1);
      check("R4 strobe cycles", sr, exp_str + 4);
      check("R3 fuse address", {23'd0, seen_addr}, (exp_base + acc_idx) % 256);
      acc_idx++; su = 0; sr = 0;
    end
    prev_sr = fuse_strobe;
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_idx = 4'(idx); bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    bus_idx = 4'(idx); #1 d = bus_rdata;
  endtask

  task automatic start_read(input int sbyte, input int len, input int adj, input int str);
    logic [31:0] v;
    wr(1, (adj << 20) | (str << 16));
    exp_adj = adj; exp_str = str; exp_base = sbyte >> 2; acc_idx = 0; su = 0; sr = 0;
    wr(0, (sbyte << 21) | (len << 16) | 1);
    rd(2, v); check("R2 done cleared", v, 0);
    rd(0, v); check("R2 command readback", v, (sbyte << 21) | (len << 16) | 1);
  endtask

  task automatic finish_read(input int len);
    logic [31:0] v;
    int words, t;
    words = (len >> 2) + 1; t = 0;
    rd(2, v);
    while (v[0] !== 1'b1 && t < 5000) begin @(negedge clk); rd(2, v); t++; end
    check("R6 done set", v, 1);
    check("R5 word count", acc_idx, words);
    rd(0, v); check("R6 request cleared", {31'd0, v[0]}, 0);
    for (int n = 0; n < words; n++) exp_data[n] = fval(8'((exp_base + n) % 256));
    for (int n = 0; n < 8; n++) begin rd(3 + n, v); check("R5 result register", v, exp_data[n]); end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int a0;
    for (int n = 0; n < 8; n++) exp_data[n] = '0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 11; i++) begin rd(i, v); check("R1 reset register", v, 0); end
    check("R1 idle fuse pins", {30'd0, fuse_en, fuse_strobe}, 0);

    wr(1, 32'hFFFF_FFFF); rd(1, v); check("R9 timing readback", v, 32'h80FF_FFFF);
    wr(1, 32'h8054_3ABC); rd(1, v); check("R9 timing fields", v, 32'h8054_3ABC);

    for (int adj = 0; adj < 16; adj++)
      for (int str = 0; str < 16; str++) begin
        int len;
        len = ((adj + str) % 8) * 4 + 3;
        start_read(((adj * 16 + str) % 32) * 32, len, adj, str);
        finish_read(len);
      end

    start_read(37, 3, 2, 1); finish_read(3);
    start_read(96, 31, 0, 0); finish_read(31);
    start_read(992, 7, 1, 0); finish_read(7);

    start_read(160, 31, 15, 15);
    repeat (10) @(negedge clk);
    wr(0, (640 << 21) | (31 << 16) | 1);
    rd(0, v); check("R7 command unchanged", v, (160 << 21) | (31 << 16) | 1);
    finish_read(31);

    a0 = acc_idx;
    wr(0, 32'h0000_8002);
    rd(0, v); check("R8 stored fields", v, 32'h0000_8002);
    repeat (40) @(negedge clk);
    check("R8 no fuse access", acc_idx, a0);
    rd(2, v); check("R8 status unchanged", v, 1);

    wr(2, 0); rd(2, v); check("R10 status write ignored", v, 1);
    for (int n = 0; n < 8; n++) begin
      wr(3 + n, 32'hDEAD_BEEF); rd(3 + n, v); check("R10 result write ignored", v, exp_data[n]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule